// File: doc/BRIEF.md
# Victim Line Buffer

This block sits next to a direct-mapped data cache and keeps the lines that the cache throws out. Each line the main cache evicts arrives on the insert port with its line address, data and dirty flag. When the main cache misses, it first probes this buffer. On a hit the line goes back to the main cache, together with its dirty flag, and leaves the buffer. Only on a miss does the main cache go to the next level. The buffer gives extra associativity to the few sets that conflict most, at the cost of a handful of entries.

The buffer is fully associative and holds 4 or 8 entries. It tracks the order in which lines were inserted. When a line must be inserted and no entry is free, the oldest inserted line is pushed out. A dirty line that is pushed out leaves on the writeback port. A probe that hits frees its entry. The main cache's displaced line, inserted in the same cycle or later, fills that entry, so a swap never evicts anything.

Top module: `victim_cache`

## Requirements
- R1: After reset no entry is valid: a probe before any insert answers with a miss, and the writeback port stays idle.
- R2: A probe of an inserted line answers exactly one cycle after the request with a hit, the stored line data on ret_data and the stored dirty flag on ret_dirty.
- R3: Every probe request produces exactly one single-cycle response, either hit or miss and never both, and no response appears without a request.
- R4: A line that hits is handed back and removed, so a second probe of the same address misses.
- R5: Any set of distinct addresses, up to the entry count, can be held at once, including addresses that collide in the main cache, and each one hits.
- R6: Inserting into a full buffer replaces the line that was inserted earliest among those present; that address then misses and the others still hit.
- R7: A replaced line that is dirty appears on the writeback port (wb_valid high for one cycle, its address and data) in the cycle after the insert; a replaced clean line produces no writeback.
- R8: An entry freed by a hit is used by the next insert, which then pushes nothing out.
- R9: If a probe and an insert carry the same address in the same cycle, the probe hits and returns the inserted data and dirty flag; the line is not kept in the buffer.
- R10: A probe that hits a full buffer while a different line is inserted in the same cycle (a swap) places the new line in the freed entry; no line is pushed out and no writeback occurs.
- R11: After lines are removed by hits, the remaining lines keep their relative age, so later replacements still take the earliest inserted remaining line first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| probe_valid | input | 1 | Probe request from a main-cache miss |
| probe_addr | input | ADDR_W | Line address being probed |
| vict_valid | input | 1 | Evicted main-cache line to insert |
| vict_addr | input | ADDR_W | Line address of the evicted line |
| vict_data | input | LINE_W | Data of the evicted line |
| vict_dirty | input | 1 | Dirty flag of the evicted line |
| probe_hit | output | 1 | Probe found the line (one cycle after the request) |
| probe_miss | output | 1 | Probe did not find the line (one cycle after the request) |
| ret_data | output | LINE_W | Line data returned to the main cache on a hit |
| ret_dirty | output | 1 | Dirty flag of the returned line |
| wb_valid | output | 1 | A dirty line was pushed out and must be written to the next level |
| wb_addr | output | ADDR_W | Address of the pushed-out line |
| wb_data | output | LINE_W | Data of the pushed-out line |

## Verification
The hardest case to reach is a swap on a full buffer, where a hit and an insert land on the same clock edge. The freed entry must take the new line, and the insertion ages of the other lines must shift by the right amount so the next replacement picks the correct line. The bench fills the buffer with dirty lines and then drives a probe and an insert in the same cycle. It then inserts again and observes on the writeback port which address comes out. A wrong age update shows up there as the wrong address, or as no writeback at all.

// File: rtl/vc_pkg.sv
package vc_pkg;

  // Age rank update for one surviving entry. Ranks count how many younger
  // lines exist: a freed line's elders slide down, an insert pushes all up.
  function automatic int unsigned age_after(int unsigned age,
                                            int unsigned freed_age,
                                            bit          freeing,
                                            bit          bump);
    int unsigned a;
    a = age;
    if (freeing && (age > freed_age)) a = a - 1;
    if (bump) a = a + 1;
    return a;
  endfunction

  // Test data helper shared in spirit with the bench: rank of the oldest line.
  function automatic int unsigned oldest_rank(int unsigned entries);
    return entries - 1;
  endfunction

endpackage

// File: rtl/vc_match.sv
module vc_match #(
  parameter int N  = 4,
  parameter int AW = 26,
  parameter int IW = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         entry_vld,
  input  logic [N-1:0][AW-1:0] entry_tag,
  input  logic [AW-1:0]        key,
  output logic [N-1:0]         hit_vec,
  output logic                 hit_any,
  output logic [IW-1:0]        hit_idx
);

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_cmp
      assign hit_vec[g] = entry_vld[g] && (entry_tag[g] == key);
    end
  endgenerate

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) hit_idx = IW'(i);
    end
  end

  assign hit_any = |hit_vec;

  // R5: each held address is present in one entry only
  assert_unique_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

endmodule

// File: rtl/vc_alloc.sv
module vc_alloc #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         entry_vld,
  input  logic [N-1:0][IW-1:0] entry_age,
  input  logic                 reuse,
  input  logic [IW-1:0]        reuse_idx,
  output logic [IW-1:0]        slot,
  output logic                 evict
);

  localparam logic [IW-1:0] OLDEST = IW'(vc_pkg::oldest_rank(N));

  logic [N-1:0]  oldest_vec;
  logic          free_any;
  logic [IW-1:0] free_idx;
  logic [IW-1:0] old_idx;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_old
      assign oldest_vec[g] = entry_vld[g] && (entry_age[g] == OLDEST);
    end
  endgenerate

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    old_idx  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!entry_vld[i]) begin
        free_any = 1'b1;
        free_idx = IW'(i);
      end
    end
    for (int i = 0; i < N; i++) begin
      if (oldest_vec[i]) old_idx = IW'(i);
    end
  end

  always_comb begin
    if (reuse)         slot = reuse_idx;
    else if (free_any) slot = free_idx;
    else               slot = old_idx;
    evict = !reuse && !free_any;
  end

  // R6: a full buffer always has exactly one earliest-inserted line
  assert_single_oldest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (&entry_vld) |-> ($countones(oldest_vec) == 1));

endmodule

// File: rtl/victim_cache.sv
module victim_cache #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 26,
  parameter int LINE_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              probe_valid,
  input  logic [ADDR_W-1:0] probe_addr,
  input  logic              vict_valid,
  input  logic [ADDR_W-1:0] vict_addr,
  input  logic [LINE_W-1:0] vict_data,
  input  logic              vict_dirty,
  output logic              probe_hit,
  output logic              probe_miss,
  output logic [LINE_W-1:0] ret_data,
  output logic              ret_dirty,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [LINE_W-1:0] wb_data
);

  localparam int IW = $clog2(ENTRIES);

  logic [ENTRIES-1:0]             vld_q;
  logic [ENTRIES-1:0]             dty_q;
  logic [ENTRIES-1:0][IW-1:0]     age_q;
  logic [ENTRIES-1:0][ADDR_W-1:0] tag_q;
  logic [ENTRIES-1:0][LINE_W-1:0] dat_q;

  // named internal events
  logic [ENTRIES-1:0] hit_vec;
  logic               match_any;
  logic [IW-1:0]      hit_idx;
  logic               fwd_hit;
  logic               take_line;
  logic               store_ins;
  logic [IW-1:0]      slot;
  logic               alloc_evict;
  logic               push_out;
  logic [ENTRIES-1:0] wr_vec;
  logic [ENTRIES-1:0] free_vec;

  vc_match #(.N(ENTRIES), .AW(ADDR_W), .IW(IW)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .entry_vld (vld_q),
    .entry_tag (tag_q),
    .key       (probe_addr),
    .hit_vec   (hit_vec),
    .hit_any   (match_any),
    .hit_idx   (hit_idx)
  );

  assign fwd_hit   = probe_valid && vict_valid && (vict_addr == probe_addr);
  assign take_line = probe_valid && match_any && !fwd_hit;
  assign store_ins = vict_valid && !fwd_hit;

  vc_alloc #(.N(ENTRIES), .IW(IW)) u_alloc (
    .clk       (clk),
    .rst_n     (rst_n),
    .entry_vld (vld_q),
    .entry_age (age_q),
    .reuse     (take_line),
    .reuse_idx (hit_idx),
    .slot      (slot),
    .evict     (alloc_evict)
  );

  assign push_out = store_ins && alloc_evict;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_ctl
      assign wr_vec[g]   = store_ins && (slot == IW'(g));
      assign free_vec[g] = take_line && hit_vec[g];
    end
  endgenerate

  // entry control state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      dty_q <= '0;
      age_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (wr_vec[i]) begin
          vld_q[i] <= 1'b1;
          dty_q[i] <= vict_dirty;
          age_q[i] <= '0;
        end else begin
          if (free_vec[i]) vld_q[i] <= 1'b0;
          if (vld_q[i] && !free_vec[i])
            age_q[i] <= IW'(vc_pkg::age_after(32'(age_q[i]), 32'(age_q[hit_idx]),
                                              take_line, store_ins));
        end
      end
    end
  end

  // entry payload
  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (wr_vec[i]) begin
        tag_q[i] <= vict_addr;
        dat_q[i] <= vict_data;
      end
    end
  end

  // probe response, one cycle after the request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      probe_hit  <= 1'b0;
      probe_miss <= 1'b0;
      ret_data   <= '0;
      ret_dirty  <= 1'b0;
    end else begin
      probe_hit  <= probe_valid && (fwd_hit || match_any);
      probe_miss <= probe_valid && !(fwd_hit || match_any);
      ret_data   <= fwd_hit ? vict_data  : dat_q[hit_idx];
      ret_dirty  <= fwd_hit ? vict_dirty : dty_q[hit_idx];
    end
  end

  // writeback of a dirty pushed-out line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_addr  <= '0;
      wb_data  <= '0;
    end else begin
      wb_valid <= push_out && dty_q[slot];
      wb_addr  <= tag_q[slot];
      wb_data  <= dat_q[slot];
    end
  end

  // R3: hit and miss never together
  assert_hit_miss_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(probe_hit && probe_miss));

  // R3: a request yields a response on the next cycle
  assert_resp_follows_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    probe_valid |=> (probe_hit || probe_miss));

  // R3: no response without a request
  assert_no_spurious_resp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !probe_valid |=> !(probe_hit || probe_miss));

  // R1: a hit needs a held line or a same-cycle insert
  assert_hit_needs_line_R1: assert property (@(posedge clk) disable iff (!rst_n)
    probe_hit |-> $past((|vld_q) || vict_valid));

  // R7: writeback only follows an insert
  assert_wb_after_insert_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(vict_valid));

  // R10: a swap never pushes a line out
  assert_swap_no_push_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (take_line && vict_valid) |=> !wb_valid);

endmodule

// File: tb/tb_victim_cache.sv
`timescale 1ns/1ps
module tb_victim_cache;

  localparam int AW = 26;
  localparam int LW = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          probe_valid;
  logic [AW-1:0] probe_addr;
  logic          vict_valid;
  logic [AW-1:0] vict_addr;
  logic [LW-1:0] vict_data;
  logic          vict_dirty;
  logic          probe_hit, probe_miss, ret_dirty, wb_valid;
  logic [LW-1:0] ret_data, wb_data;
  logic [AW-1:0] wb_addr;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  victim_cache #(.ENTRIES(4), .ADDR_W(AW), .LINE_W(LW)) dut (
    .clk(clk), .rst_n(rst_n),
    .probe_valid(probe_valid), .probe_addr(probe_addr),
    .vict_valid(vict_valid), .vict_addr(vict_addr),
    .vict_data(vict_data), .vict_dirty(vict_dirty),
    .probe_hit(probe_hit), .probe_miss(probe_miss),
    .ret_data(ret_data), .ret_dirty(ret_dirty),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  function automatic logic [LW-1:0] pat(logic [AW-1:0] a);
    return {8'hC3, 30'(a) ^ 30'h155, 26'(a) + 26'd7};
  endfunction

  task automatic check(string req, string what, logic [LW-1:0] got, logic [LW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic idle_inputs();
    probe_valid = 1'b0; probe_addr = '0;
    vict_valid = 1'b0; vict_addr = '0; vict_data = '0; vict_dirty = 1'b0;
  endtask

  // drive one cycle of stimulus; returns after the edge, outputs settled
  task automatic step(logic pv, logic [AW-1:0] pa,
                      logic iv, logic [AW-1:0] ia, logic idt);
    probe_valid = pv; probe_addr = pa;
    vict_valid = iv; vict_addr = ia; vict_data = pat(ia); vict_dirty = idt;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic insert(logic [AW-1:0] a, logic d);
    step(1'b0, '0, 1'b1, a, d);
  endtask

  task automatic expect_hit(string req, logic [AW-1:0] a, logic d);
    step(1'b1, a, 1'b0, '0, 1'b0);
    check(req, "hit", LW'(probe_hit), 1);
    check(req, "miss", LW'(probe_miss), 0);
    check(req, "data", ret_data, pat(a));
    check(req, "dirty", LW'(ret_dirty), LW'(d));
  endtask

  task automatic expect_miss(string req, logic [AW-1:0] a);
    step(1'b1, a, 1'b0, '0, 1'b0);
    check(req, "hit", LW'(probe_hit), 0);
    check(req, "miss", LW'(probe_miss), 1);
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1", "hit after reset", LW'(probe_hit), 0);
    check("R1", "wb after reset", LW'(wb_valid), 0);
    expect_miss("R1", 26'h0);
    expect_miss("R1", 26'h3FF_0000);
  endtask

  task automatic t_basic();
    do_reset();
    insert(26'h12345, 1'b1);
    check("R1", "no wb on fill", LW'(wb_valid), 0);
    expect_hit("R2", 26'h12345, 1'b1);
    @(negedge clk);
    check("R3", "hit pulse ends", LW'(probe_hit), 0);
    check("R3", "no miss idle", LW'(probe_miss), 0);
    expect_miss("R4", 26'h12345);
  endtask

  task automatic t_assoc();
    do_reset();
    insert(26'h0100, 1'b0);
    insert(26'h1100, 1'b1);
    insert(26'h2100, 1'b0);
    insert(26'h3100, 1'b1);
    check("R5", "no wb when filling", LW'(wb_valid), 0);
    expect_hit("R5", 26'h3100, 1'b1);
    expect_hit("R5", 26'h0100, 1'b0);
    expect_hit("R5", 26'h2100, 1'b0);
    expect_hit("R5", 26'h1100, 1'b1);
  endtask

  task automatic t_fifo();
    do_reset();
    insert(26'hA, 1'b1);
    insert(26'hB, 1'b0);
    insert(26'hC, 1'b1);
    insert(26'hD, 1'b0);
    insert(26'hE, 1'b0);
    check("R7", "wb valid dirty push", LW'(wb_valid), 1);
    check("R7", "wb addr", LW'(wb_addr), LW'(26'hA));
    check("R7", "wb data", wb_data, pat(26'hA));
    @(negedge clk);
    check("R7", "wb pulse ends", LW'(wb_valid), 0);
    expect_miss("R6", 26'hA);
    insert(26'hF, 1'b0);
    check("R7", "clean push no wb", LW'(wb_valid), 0);
    expect_miss("R6", 26'hB);
    expect_hit("R6", 26'hC, 1'b1);
    expect_hit("R6", 26'hF, 1'b0);
  endtask

  task automatic t_reuse();
    do_reset();
    insert(26'h21, 1'b1);
    insert(26'h22, 1'b1);
    insert(26'h23, 1'b1);
    insert(26'h24, 1'b1);
    expect_hit("R8", 26'h22, 1'b1);
    insert(26'h25, 1'b1);
    check("R8", "freed entry reused, no wb", LW'(wb_valid), 0);
    insert(26'h26, 1'b1);
    check("R11", "wb valid", LW'(wb_valid), 1);
    check("R11", "oldest out first", LW'(wb_addr), LW'(26'h21));
    insert(26'h27, 1'b1);
    check("R11", "next oldest out", LW'(wb_addr), LW'(26'h23));
    expect_hit("R11", 26'h24, 1'b1);
    expect_hit("R11", 26'h25, 1'b1);
  endtask

  task automatic t_fwd();
    do_reset();
    insert(26'h77, 1'b0);
    step(1'b1, 26'h99, 1'b1, 26'h99, 1'b1);
    check("R9", "forward hit", LW'(probe_hit), 1);
    check("R9", "forward data", ret_data, pat(26'h99));
    check("R9", "forward dirty", LW'(ret_dirty), 1);
    expect_miss("R9", 26'h99);
    expect_hit("R9", 26'h77, 1'b0);
  endtask

  task automatic t_swap();
    do_reset();
    insert(26'h41, 1'b1);
    insert(26'h42, 1'b0);
    insert(26'h43, 1'b1);
    insert(26'h44, 1'b1);
    step(1'b1, 26'h42, 1'b1, 26'h45, 1'b1);
    check("R10", "swap hit", LW'(probe_hit), 1);
    check("R10", "swap data", ret_data, pat(26'h42));
    check("R10", "swap no wb", LW'(wb_valid), 0);
    insert(26'h46, 1'b0);
    check("R10", "after swap wb", LW'(wb_valid), 1);
    check("R10", "after swap oldest", LW'(wb_addr), LW'(26'h41));
    expect_hit("R10", 26'h45, 1'b1);
    expect_hit("R10", 26'h43, 1'b1);
    expect_hit("R10", 26'h44, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    idle_inputs();
    @(negedge clk);
    t_reset();
    t_basic();
    t_assoc();
    t_fifo();
    t_reuse();
    t_fwd();
    t_swap();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule